// File: doc/BRIEF.md
# Trace Log Row Packing Queue

This block accepts trace events that have already been filtered and turns each one into a 64-bit log row held in a small first-word-fall-through queue. An event is either a tag, which is an 8-bit or 16-bit marker placed at a decision point, or a register value of up to 32 bits. A static capture-mode input chooses what accompanies the payload. In timer mode a row carries a timestamp. In program-counter mode it carries the address of the instruction that produced the event. No row records which of the two modes was active.

Software reads the oldest row as two 32-bit words: the low word first, then the high word. Reading the high word retires the row. The event type always sits in bit 0 of the low word, so a reader can branch on a single AND. Tags always start at bit 0 of the high word, so they stay aligned to 32 bits. Three sticky flags record lost events and timer wraps between rows: one for queue overflow and one for each of the two timers.

Top module: `trace_row_fifo`

## Requirements
- R1: Each accepted event writes exactly one row. When the queue is not empty, `rd_lo_data` and `rd_hi_data` show the oldest row. The queue holds DEPTH (default 16) rows. `fifo_empty` and `fifo_full` report the two extremes.
- R2: Low-word bit 0 is 1 for a tag row and 0 for a register row, in both capture modes.
- R3: A tag always occupies high-word bits [15:0]. When `evt_tag_wide` is 0, only `evt_data[7:0]` is used and high-word bits [15:8] are 0, whatever `evt_data[15:8]` holds.
- R4: A tag row in timer mode (`cfg_pc_mode`=0) has this layout: low[31:3] = timer-1 bits [28:0], low[2] = timer-1 wrap flag, low[1] = queue overflow flag, high[31:16] = timer-1 bits [44:29].
- R5: A register row in timer mode has this layout: high word = `evt_data`, low[31:3] = timer-2 count, low[2] = timer-2 wrap flag, low[1] = queue overflow flag.
- R6: In program-counter mode (`cfg_pc_mode`=1), both row types put `evt_pc[30:1]` in low[31:2] and the queue overflow flag in low[1]. Tag rows have high[31:16] = 0, and register rows carry `evt_data` in the high word. No timer flag is recorded, and no timer flag is consumed.
- R7: A pulse on `rd_hi` retires the oldest row only if `rd_lo` was pulsed for that row since the last retirement. A `rd_hi` pulse without that has no effect.
- R8: An event that arrives while the queue is full, with no retirement in the same cycle, is dropped and sets the sticky queue overflow flag. The next accepted row has low[1] = 1, and the flag then clears, so the row after that has low[1] = 0.
- R9: A pulse on `tmr1_wrap` or `tmr2_wrap` sets that timer's flag. The flag is written into the next timer-mode row of the matching type (tag for timer 1, register for timer 2) and is then cleared. A wrap in the same cycle as that recording keeps the flag set for the following row.
- R10: A write and a retirement in the same cycle on a non-empty queue leave the occupancy unchanged. This holds when the queue is full, and the event is then accepted, not dropped.
- R11: `rst_n` low empties the queue and clears all three sticky flags. Its release passes through two flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pc_mode | input | 1 | Capture mode: 0 timer, 1 program counter |
| evt_valid | input | 1 | Event present this cycle |
| evt_is_tag | input | 1 | 1 tag event, 0 register event |
| evt_tag_wide | input | 1 | 1 for a 16-bit tag, 0 for an 8-bit tag |
| evt_data | input | 32 | Tag (low bits) or register content |
| evt_pc | input | 32 | Program counter of the event |
| tmr1_count | input | 45 | Timer-1 timestamp used by tag rows |
| tmr1_wrap | input | 1 | Timer-1 wrapped this cycle |
| tmr2_count | input | 29 | Timer-2 count used by register rows |
| tmr2_wrap | input | 1 | Timer-2 wrapped this cycle |
| rd_lo | input | 1 | Read strobe for the low word |
| rd_hi | input | 1 | Read strobe for the high word, retires the row |
| rd_lo_data | output | 32 | Low word of the oldest row |
| rd_hi_data | output | 32 | High word of the oldest row |
| fifo_empty | output | 1 | No row stored |
| fifo_full | output | 1 | DEPTH rows stored |

## Verification
Two pairs of functions can land in the same cycle.

- **Write and retirement on a full queue.** The bench fills the queue, reads the low word of the oldest row, and then raises `rd_hi` in the same cycle as a new event. It then checks three things: the queue is still full, all sixteen drained rows match the scoreboard, and the next row carries no overflow mark.
- **Timer wrap and the recording that would clear its flag.** The bench pulses a timer wrap in the same cycle as a matching event. That row must show the flag as it was before the wrap, and the next matching row must show it set.

// File: rtl/trace_row_pkg.sv
package trace_row_pkg;
  localparam int WORD_W  = 32;
  localparam int TAG_W   = 16;
  localparam int TAG8_W  = 8;
  localparam int TMR1_W  = 45;
  localparam int TMR2_W  = 29;
  localparam int LO_TS_W = WORD_W - 3;
  localparam int HI_TS_W = TMR1_W - LO_TS_W;
  localparam int PC_KEEP = WORD_W - 2;
  localparam int NUM_TMR = 2;

  typedef struct packed {
    logic [WORD_W-1:0] hi;
    logic [WORD_W-1:0] lo;
  } row_t;

  typedef enum logic {
    CAP_TIMER = 1'b0,
    CAP_PC    = 1'b1
  } cap_mode_e;

  typedef enum logic {
    EV_REG = 1'b0,
    EV_TAG = 1'b1
  } ev_kind_e;
endpackage

// File: rtl/trace_row_packer.sv
module trace_row_packer
  import trace_row_pkg::*;
(
  input  cap_mode_e                mode,
  input  ev_kind_e                 kind,
  input  logic                     tag_wide,
  input  logic [WORD_W-1:0]        data,
  input  logic [WORD_W-1:0]        pc,
  input  logic [TMR1_W-1:0]        t1,
  input  logic [TMR2_W-1:0]        t2,
  input  logic                     t1_flag,
  input  logic                     t2_flag,
  input  logic                     fifo_flag,
  output row_t                     row
);
  logic [TAG_W-1:0] tag_field;

  always_comb begin
    if (tag_wide) begin
      tag_field = data[TAG_W-1:0];
    end else begin
      tag_field = {{(TAG_W-TAG8_W){1'b0}}, data[TAG8_W-1:0]};
    end
  end

  always_comb begin
    row = '0;
    if (mode == CAP_PC) begin
      row.lo = {pc[PC_KEEP:1], fifo_flag, kind};
      if (kind == EV_TAG) begin
        row.hi = {{(WORD_W-TAG_W){1'b0}}, tag_field};
      end else begin
        row.hi = data;
      end
    end else if (kind == EV_TAG) begin
      row.lo = {t1[LO_TS_W-1:0], t1_flag, fifo_flag, 1'b1};
      row.hi = {t1[TMR1_W-1:LO_TS_W], tag_field};
    end else begin
      row.lo = {t2, t2_flag, fifo_flag, 1'b0};
      row.hi = data;
    end
  end
endmodule

// File: rtl/trace_flag_keeper.sv
module trace_flag_keeper
  import trace_row_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  cap_mode_e          mode,
  input  ev_kind_e           kind,
  input  logic               accept,
  input  logic               drop,
  input  logic [NUM_TMR-1:0] tmr_wrap,
  output logic               fifo_flag_q,
  output logic [NUM_TMR-1:0] tmr_flag_q
);
  logic               fifo_flag_d;
  logic [NUM_TMR-1:0] tmr_flag_d;
  logic [NUM_TMR-1:0] tmr_consume;

  always_comb begin
    fifo_flag_d = fifo_flag_q;
    if (drop) begin
      fifo_flag_d = 1'b1;
    end else if (accept) begin
      fifo_flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_flag_q <= 1'b0;
    end else if (drop || accept) begin
      fifo_flag_q <= fifo_flag_d;
    end
  end

  // Timer 0 pairs with tag rows and timer 1 with register rows.
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam ev_kind_e OWN_KIND = (i == 0) ? EV_TAG : EV_REG;

    assign tmr_consume[i] = accept && (mode == CAP_TIMER) && (kind == OWN_KIND);

    always_comb begin
      tmr_flag_d[i] = tmr_wrap[i] | (tmr_flag_q[i] & ~tmr_consume[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tmr_flag_q[i] <= 1'b0;
      end else if (tmr_wrap[i] || tmr_consume[i]) begin
        tmr_flag_q[i] <= tmr_flag_d[i];
      end
    end

    AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_wrap[i] |=> tmr_flag_q[i]); // R9
  end

  AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> fifo_flag_q); // R8
  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !fifo_flag_q); // R8
endmodule

// File: rtl/trace_read_gate.sv
module trace_read_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_lo,
  input  logic rd_hi,
  input  logic empty,
  output logic pop
);
  logic lo_seen_q;
  logic lo_seen_d;

  assign pop = rd_hi && lo_seen_q && !empty;

  always_comb begin
    if (pop) begin
      lo_seen_d = 1'b0;
    end else begin
      lo_seen_d = lo_seen_q | (rd_lo & ~empty);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_seen_q <= 1'b0;
    end else if (pop || rd_lo) begin
      lo_seen_q <= lo_seen_d;
    end
  end

  AST_POP_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !lo_seen_q || $past(rd_lo)); // R7
endmodule

// File: rtl/trace_row_store.sv
module trace_row_store
  import trace_row_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  row_t wr_row,
  output row_t head_row,
  output logic empty,
  output logic full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   LVL_FULL = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  row_t            mem_q [DEPTH];
  logic [AW-1:0]   wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]   rd_ptr_q, rd_ptr_d;
  logic [AW:0]     level_q, level_d;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (level_q == '0);
  assign full     = (level_q == LVL_FULL);
  assign head_row = mem_q[rd_ptr_q];

  always_comb begin
    wr_ptr_d = push ? ptr_next(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop  ? ptr_next(rd_ptr_q) : rd_ptr_q;
    level_d  = level_q;
    if (push && !pop) begin
      level_d = level_q + 1'b1;
    end else if (pop && !push) begin
      level_d = level_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else if (push || pop) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem_q[wr_ptr_q] <= wr_row;
    end
  end

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !(push && !pop)); // R8
  AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop); // R7
  AST_KEEP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> (full == $past(full)) && !empty); // R10
  AST_ONE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> !empty); // R1
endmodule

// File: rtl/trace_row_fifo.sv
module trace_row_fifo
  import trace_row_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_pc_mode,
  input  logic                 evt_valid,
  input  logic                 evt_is_tag,
  input  logic                 evt_tag_wide,
  input  logic [WORD_W-1:0]    evt_data,
  input  logic [WORD_W-1:0]    evt_pc,
  input  logic [TMR1_W-1:0]    tmr1_count,
  input  logic                 tmr1_wrap,
  input  logic [TMR2_W-1:0]    tmr2_count,
  input  logic                 tmr2_wrap,
  input  logic                 rd_lo,
  input  logic                 rd_hi,
  output logic [WORD_W-1:0]    rd_lo_data,
  output logic [WORD_W-1:0]    rd_hi_data,
  output logic                 fifo_empty,
  output logic                 fifo_full
);
  logic               rst_meta_q, rst_sync_q;
  logic               pop, accept, drop;
  logic               fifo_flag;
  logic [NUM_TMR-1:0] tmr_flag;
  cap_mode_e          mode;
  ev_kind_e           kind;
  row_t               new_row;
  row_t               head_row;

  // Reset asserts at once and is released through two flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign mode   = cap_mode_e'(cfg_pc_mode);
  assign kind   = ev_kind_e'(evt_is_tag);
  assign accept = evt_valid && (!fifo_full || pop);
  assign drop   = evt_valid && fifo_full && !pop;

  trace_read_gate u_gate (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .rd_lo (rd_lo),
    .rd_hi (rd_hi),
    .empty (fifo_empty),
    .pop   (pop)
  );

  trace_flag_keeper u_flags (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .mode        (mode),
    .kind        (kind),
    .accept      (accept),
    .drop        (drop),
    .tmr_wrap    ({tmr2_wrap, tmr1_wrap}),
    .fifo_flag_q (fifo_flag),
    .tmr_flag_q  (tmr_flag)
  );

  trace_row_packer u_pack (
    .mode      (mode),
    .kind      (kind),
    .tag_wide  (evt_tag_wide),
    .data      (evt_data),
    .pc        (evt_pc),
    .t1        (tmr1_count),
    .t2        (tmr2_count),
    .t1_flag   (tmr_flag[0]),
    .t2_flag   (tmr_flag[1]),
    .fifo_flag (fifo_flag),
    .row       (new_row)
  );

  trace_row_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .push     (accept),
    .pop      (pop),
    .wr_row   (new_row),
    .head_row (head_row),
    .empty    (fifo_empty),
    .full     (fifo_full)
  );

  assign rd_lo_data = head_row.lo;
  assign rd_hi_data = head_row.hi;

  AST_TYPE_BIT: assert property (@(posedge clk) disable iff (!rst_sync_q)
    accept |-> (new_row.lo[0] == evt_is_tag)); // R2
  AST_PC_RSVD: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (accept && cfg_pc_mode && evt_is_tag) |-> (new_row.hi[WORD_W-1:TAG_W] == '0)); // R6
  AST_NARROW_TAG: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (accept && evt_is_tag && !evt_tag_wide) |-> (new_row.hi[TAG_W-1:TAG8_W] == '0)); // R3
endmodule

// File: tb/trace_row_fifo_tb.sv
`timescale 1ns/1ps
module trace_row_fifo_tb;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_pc_mode, evt_valid, evt_is_tag, evt_tag_wide;
  logic [31:0] evt_data, evt_pc;
  logic [44:0] tmr1_count;
  logic        tmr1_wrap;
  logic [28:0] tmr2_count;
  logic        tmr2_wrap, rd_lo, rd_hi;
  logic [31:0] rd_lo_data, rd_hi_data;
  logic        fifo_empty, fifo_full;

  int checks = 0;
  int fails  = 0;
  logic [63:0] exp_q[$];
  int  m_cnt;
  bit  m_fo, m_t1, m_t2;

  always #2.5 clk = ~clk;

  trace_row_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_pc_mode(cfg_pc_mode), .evt_valid(evt_valid),
    .evt_is_tag(evt_is_tag), .evt_tag_wide(evt_tag_wide), .evt_data(evt_data),
    .evt_pc(evt_pc), .tmr1_count(tmr1_count), .tmr1_wrap(tmr1_wrap),
    .tmr2_count(tmr2_count), .tmr2_wrap(tmr2_wrap), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .rd_lo_data(rd_lo_data), .rd_hi_data(rd_hi_data),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Expected row built from the requirement text.
  function automatic logic [63:0] mk(bit tag, bit wide, logic [31:0] d, logic [31:0] pc);
    logic [15:0] t16;
    logic [31:0] lo, hi;
    t16 = wide ? d[15:0] : {8'h00, d[7:0]};
    if (cfg_pc_mode) begin
      lo = {pc[30:1], m_fo, tag};
      hi = tag ? {16'h0000, t16} : d;
    end else if (tag) begin
      lo = {tmr1_count[28:0], m_t1, m_fo, 1'b1};
      hi = {tmr1_count[44:29], t16};
    end else begin
      lo = {tmr2_count, m_t2, m_fo, 1'b0};
      hi = d;
    end
    return {hi, lo};
  endfunction

  // Driver: presents one event and updates the scoreboard.
  task automatic send(input bit tag, input bit wide, input logic [31:0] d,
                      input logic [31:0] pc, input bit popping);
    evt_valid = 1'b1; evt_is_tag = tag; evt_tag_wide = wide;
    evt_data = d; evt_pc = pc;
    if (m_cnt < DEPTH || popping) begin
      exp_q.push_back(mk(tag, wide, d, pc));
      if (!popping) m_cnt++;
      m_fo = 1'b0;
      if (!cfg_pc_mode && tag)  m_t1 = 1'b0;
      if (!cfg_pc_mode && !tag) m_t2 = 1'b0;
    end else begin
      m_fo = 1'b1;
    end
    step();
    evt_valid = 1'b0;
  endtask

  // Monitor side: compares the head row against the scoreboard, then retires it.
  task automatic read_row(input string req);
    logic [63:0] e;
    chk({req, " not empty"}, 64'(fifo_empty), 64'd0);
    e = exp_q.pop_front();
    chk(req, {rd_hi_data, rd_lo_data}, e);
    rd_lo = 1'b1; step(); rd_lo = 1'b0;
    rd_hi = 1'b1; step(); rd_hi = 1'b0;
    m_cnt--;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
    repeat (3) step();
    exp_q.delete();
    m_cnt = 0; m_fo = 0; m_t1 = 0; m_t2 = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cfg_pc_mode = 0; evt_valid = 0; evt_is_tag = 0; evt_tag_wide = 0;
    evt_data = 0; evt_pc = 0; tmr1_count = 45'h1ABC_DEF0_1234; tmr1_wrap = 0;
    tmr2_count = 29'h0123_4567; tmr2_wrap = 0; rd_lo = 0; rd_hi = 0;
    do_reset();
    chk("R11 empty after reset", 64'(fifo_empty), 64'd1);
    chk("R11 not full after reset", 64'(fifo_full), 64'd0);

    // R2 R3 R4 R5: timer-mode layouts
    send(1, 0, 32'h0000_AB5C, 32'h0, 0);
    send(1, 1, 32'h0000_BEEF, 32'h0, 0);
    send(0, 0, 32'hCAFE_F00D, 32'h0, 0);
    read_row("R3 R4 narrow tag row");
    read_row("R3 R4 wide tag row");
    read_row("R2 R5 register row");
    chk("R1 empty after drain", 64'(fifo_empty), 64'd1);

    // R7: high read without low read is ignored
    send(0, 0, 32'h1111_2222, 32'h0, 0);
    send(0, 0, 32'h3333_4444, 32'h0, 0);
    rd_hi = 1'b1; step(); rd_hi = 1'b0;
    chk("R7 lone high read keeps head", {rd_hi_data, rd_lo_data}, exp_q[0]);
    read_row("R7 first row");
    read_row("R7 second row");

    // R8: overflow drop and sticky mark
    for (int i = 0; i < DEPTH; i++) send(0, 0, 32'h100 + 32'(i), 32'h0, 0);
    chk("R1 full at depth", 64'(fifo_full), 64'd1);
    send(0, 0, 32'hDEAD_DEAD, 32'h0, 0);
    for (int i = 0; i < DEPTH; i++) read_row("R8 stored rows intact");
    chk("R8 empty after drain", 64'(fifo_empty), 64'd1);
    send(1, 1, 32'h0000_0A0A, 32'h0, 0);
    send(1, 1, 32'h0000_0B0B, 32'h0, 0);
    read_row("R8 overflow marked in next row");
    read_row("R8 mark cleared afterwards");

    // R9: timer wraps
    tmr1_wrap = 1'b1; step(); tmr1_wrap = 1'b0; m_t1 = 1'b1;
    tmr2_wrap = 1'b1; step(); tmr2_wrap = 1'b0; m_t2 = 1'b1;
    send(1, 0, 32'h0000_0055, 32'h0, 0);
    send(1, 0, 32'h0000_0066, 32'h0, 0);
    send(0, 0, 32'h7777_7777, 32'h0, 0);
    read_row("R9 tag row shows timer-1 wrap");
    read_row("R9 timer-1 flag cleared");
    read_row("R9 register row shows timer-2 wrap");
    tmr1_wrap = 1'b1;
    send(1, 1, 32'h0000_1234, 32'h0, 0);
    tmr1_wrap = 1'b0; m_t1 = 1'b1;
    send(1, 1, 32'h0000_5678, 32'h0, 0);
    read_row("R9 coincident wrap not in same row");
    read_row("R9 coincident wrap kept for next row");

    // R10: write and retire in one cycle on a full queue
    for (int i = 0; i < DEPTH; i++) send(1, 1, 32'h200 + 32'(i), 32'h0, 0);
    rd_lo = 1'b1; step(); rd_lo = 1'b0;
    chk("R10 head before swap", {rd_hi_data, rd_lo_data}, exp_q.pop_front());
    rd_hi = 1'b1;
    send(0, 0, 32'hABCD_0123, 32'h0, 1);
    rd_hi = 1'b0;
    chk("R10 still full", 64'(fifo_full), 64'd1);
    for (int i = 0; i < DEPTH; i++) read_row("R10 drained rows");
    chk("R10 empty after drain", 64'(fifo_empty), 64'd1);

    // R6: program-counter mode, pending timer flag untouched
    tmr1_wrap = 1'b1; step(); tmr1_wrap = 1'b0; m_t1 = 1'b1;
    cfg_pc_mode = 1'b1;
    send(1, 0, 32'h0000_FF3C, 32'h8765_4322, 0);
    send(0, 0, 32'h0BAD_F00D, 32'h1234_5676, 0);
    read_row("R6 pc tag row");
    read_row("R6 pc register row");
    cfg_pc_mode = 1'b0;
    send(1, 1, 32'h0000_4242, 32'h0, 0);
    read_row("R6 timer flag not consumed in pc mode");

    // R11: reset clears queue and sticky overflow
    for (int i = 0; i < DEPTH + 1; i++) send(0, 0, 32'(i), 32'h0, 0);
    do_reset();
    chk("R11 empty after second reset", 64'(fifo_empty), 64'd1);
    send(0, 0, 32'h5555_AAAA, 32'h0, 0);
    read_row("R11 overflow mark cleared by reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule